// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block produces drive level codes for a multiplexed segment LCD with four common lines and a parameterized number of segment lines (43 by default). Every output pin carries a 2-bit level index. An external ladder or analog switch array turns that index into one of four voltages, V0 (ground) through V3. A one-cycle frame-clock enable paces the sequencer. A programmable divider turns that enable into slot-advance ticks. A slot counter walks through the active commons once per frame. The drive polarity flips after the last slot of each frame. Over two frames every cell therefore sees zero net DC.

Software writes an 8-bit control byte and the display pixels through two simple write ports. Each display byte holds two segments: one nibble per segment and one bit per common. When the mode field is zero, or while reset is asserted, every pin sits at level 0 and nothing is shown. Blanking keeps the waveforms alternating but drives every segment as off, so the frame clock can be changed without flicker.

Top module: `lcd_wave_seq`

## Requirements
- R1: While reset is asserted, or while the control mode field is 00, every common and segment output is level code 0.
- R2: Control byte fields: bit 4 is blank, bits 3:2 are mode, bits 1:0 are divide select, and bits 7:5 have no effect. Mode 01 is 1/2 duty with 1/2 bias, mode 10 is 1/3 duty with 1/3 bias, and mode 11 is 1/4 duty with 1/3 bias.
- R3: The slot advances once every 2^S frame-enable pulses, where S is the divide select (ratio 1, 2, 4 or 8). Between advances all outputs hold.
- R4: Slots run from 0 to duty-1 and then wrap to 0. The polarity bit toggles only on that wrap.
- R5: With 1/3 bias, a selected common is code 3 at polarity 0 and code 0 at polarity 1. An unselected common is code 1 at polarity 0 and code 2 at polarity 1.
- R6: With 1/3 bias, an on segment is code 0 at polarity 0 and code 3 at polarity 1. An off segment is code 2 at polarity 0 and code 1 at polarity 1.
- R7: With 1/2 bias, code 1 is the single mid level. Unselected commons are always code 1. Selected commons use 3/0 and on segments use 0/3 as in R5 and R6. Off segments use code 3 at polarity 0 and code 0 at polarity 1.
- R8: Commons whose index is at or beyond the active duty are always driven as unselected.
- R9: With blank set, every segment is driven as off while the commons keep sequencing.
- R10: A display write to byte address BASE+k (BASE = 0x64, k from 0 to 21) loads bits 3:0 into segment 2k and bits 7:4 into segment 2k+1. Bit c of a segment's nibble is its pixel for common c. Writes outside that window change nothing.
- R11: For every common/segment pair, the cell voltage (common minus segment) summed over two whole frames is zero in every mode.
- R12: Leaving stop mode always starts the sequence at slot 0 with polarity 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | Frame-clock enable pulse |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| ram_we | input | 1 | Display byte write strobe |
| ram_addr | input | 8 | Display byte address |
| ram_wdata | input | 8 | Display byte data |
| com_lvl | output | 8 | Level codes, common c at bits 2c+1:2c |
| seg_lvl | output | 86 | Level codes, segment s at bits 2s+1:2s |

## Verification
The hardest property to reach from the ports is the zero-DC balance. It holds only over two whole frames, and it has to hold for every pixel pattern, every duty and every divide ratio. The bench loads random display contents, enters each mode from stop, and steps exactly two frames slot by slot. At each slot it adds the decoded common-minus-segment voltage of all 172 cells and then requires every sum to be zero. Along the way it compares each slot against the code table and checks that the outputs hold through the intermediate enable pulses of the divider.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

   typedef logic [1:0] lvl_t;

   localparam lvl_t LV_GND = 2'd0;
   localparam lvl_t LV_LO  = 2'd1;
   localparam lvl_t LV_HI  = 2'd2;
   localparam lvl_t LV_TOP = 2'd3;

   typedef struct packed {
      logic       blank;
      logic [1:0] mode;
      logic [1:0] fdiv;
   } ctl_t;

   function automatic logic [2:0] duty_of(input logic [1:0] mode);
      case (mode)
         2'b01:   return 3'd2;
         2'b10:   return 3'd3;
         default: return 3'd4;
      endcase
   endfunction

   function automatic lvl_t com_code(input logic sel, input logic pol, input logic bias3);
      if (sel)        return pol ? LV_GND : LV_TOP;
      else if (bias3) return pol ? LV_HI  : LV_LO;
      else            return LV_LO;
   endfunction

   function automatic lvl_t seg_code(input logic on, input logic pol, input logic bias3);
      if (on)         return pol ? LV_TOP : LV_GND;
      else if (bias3) return pol ? LV_LO  : LV_HI;
      else            return pol ? LV_GND : LV_TOP;
   endfunction

endpackage

// File: rtl/lcd_tick_div.sv
module lcd_tick_div #(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [DIV_W-1:0] fsel,
   output logic             adv
);
   localparam int CNT_W = (1 << DIV_W) - 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   always_comb begin
      lim = CNT_W'((32'd1 << fsel) - 32'd1);
      adv = run && tick && (cnt >= lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= '0;
      else if (!run)      cnt <= '0;
      else if (tick) begin
         if (cnt >= lim)  cnt <= '0;
         else             cnt <= cnt + 1'b1;
      end
   end

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> (!run || $stable(cnt)));

endmodule

// File: rtl/lcd_slot_seq.sv
module lcd_slot_seq #(
   parameter int N_COM = 4,
   localparam int SLOT_W = $clog2(N_COM),
   localparam int DUTY_W = $clog2(N_COM + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              adv,
   input  logic [DUTY_W-1:0] duty,
   output logic [SLOT_W-1:0] slot,
   output logic              pol
);
   logic last;
   assign last = (DUTY_W'(slot) >= duty - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot <= '0;
         pol  <= 1'b0;
      end else if (!run) begin
         slot <= '0;
         pol  <= 1'b0;
      end else if (adv) begin
         if (last) begin
            slot <= '0;
            pol  <= ~pol;
         end else begin
            slot <= slot + 1'b1;
         end
      end
   end

   // R4
   pol_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && adv && last) |=> (!run || pol != $past(pol)));

   // R4
   pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !(adv && last)) |=> (!run || $stable(pol)));

   // R12
   stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (slot == '0 && !pol));

endmodule

// File: rtl/lcd_disp_ram.sv
module lcd_disp_ram #(
   parameter int         N_SEG  = 43,
   parameter int         N_COM  = 4,
   parameter int         ADDR_W = 8,
   parameter logic [7:0] BASE   = 8'h64,
   localparam int SEG_PER_B = 8 / N_COM,
   localparam int N_BYTES   = (N_SEG + SEG_PER_B - 1) / SEG_PER_B
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [7:0]             wdata,
   output logic [N_SEG*N_COM-1:0] pix
);
   for (genvar s = 0; s < N_SEG; s++) begin : g_seg
      localparam int BYTE = s / SEG_PER_B;
      localparam int LANE = s % SEG_PER_B;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pix[s*N_COM +: N_COM] <= '0;
         else if (we && addr == ADDR_W'(BASE + BYTE))
            pix[s*N_COM +: N_COM] <= wdata[LANE*N_COM +: N_COM];
      end
   end

   // R10
   idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(pix));

   // R10
   window_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (addr < ADDR_W'(BASE) || addr >= ADDR_W'(BASE + N_BYTES))) |=> $stable(pix));

endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
   import lcd_seq_pkg::*;
#(
   parameter int N_COM = 4,
   parameter int N_SEG = 43,
   localparam int SLOT_W = $clog2(N_COM),
   localparam int DUTY_W = $clog2(N_COM + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   run,
   input  logic                   blank,
   input  logic                   bias3,
   input  logic [DUTY_W-1:0]      duty,
   input  logic [SLOT_W-1:0]      slot,
   input  logic                   pol,
   input  logic [N_SEG*N_COM-1:0] pix,
   output logic [2*N_COM-1:0]     com_lvl,
   output logic [2*N_SEG-1:0]     seg_lvl
);
   for (genvar c = 0; c < N_COM; c++) begin : g_com
      logic sel;
      assign sel = (slot == SLOT_W'(c)) && (c < int'(duty));
      assign com_lvl[2*c +: 2] = run ? com_code(sel, pol, bias3) : LV_GND;

      // R8
      idle_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run && c >= int'(duty)) |-> (com_lvl[2*c +: 2] == LV_LO || com_lvl[2*c +: 2] == LV_HI));
   end

   for (genvar s = 0; s < N_SEG; s++) begin : g_seg
      logic [N_COM-1:0] bits;
      logic             on;
      assign bits = pix[s*N_COM +: N_COM];
      assign on   = bits[slot] && !blank;
      assign seg_lvl[2*s +: 2] = run ? seg_code(on, pol, bias3) : LV_GND;

      // R9
      blank_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run && blank && bias3) |-> (seg_lvl[2*s +: 2] == LV_LO || seg_lvl[2*s +: 2] == LV_HI));
   end

endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
   import lcd_seq_pkg::*;
#(
   parameter int         N_COM  = 4,
   parameter int         N_SEG  = 43,
   parameter int         ADDR_W = 8,
   parameter logic [7:0] BASE   = 8'h64,
   localparam int SLOT_W = $clog2(N_COM),
   localparam int DUTY_W = $clog2(N_COM + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_tick,
   input  logic               ctl_we,
   input  logic [7:0]         ctl_wdata,
   input  logic               ram_we,
   input  logic [ADDR_W-1:0]  ram_addr,
   input  logic [7:0]         ram_wdata,
   output logic [2*N_COM-1:0] com_lvl,
   output logic [2*N_SEG-1:0] seg_lvl
);
   if (N_COM != 4) begin : g_bad_com
      $error("lcd_wave_seq: N_COM must be 4");
   end
   if (N_SEG < 1 || N_SEG > 64) begin : g_bad_seg
      $error("lcd_wave_seq: N_SEG out of range");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("lcd_wave_seq: ADDR_W too small");
   end

   ctl_t                   ctl;
   logic                   run, bias3, adv, pol;
   logic [DUTY_W-1:0]      duty;
   logic [SLOT_W-1:0]      slot;
   logic [N_SEG*N_COM-1:0] pix;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl <= '0;
      else if (ctl_we) ctl <= ctl_wdata[4:0];
   end

   assign run   = (ctl.mode != 2'b00);
   assign bias3 = (ctl.mode != 2'b01);
   assign duty  = DUTY_W'(duty_of(ctl.mode));

   lcd_tick_div #(.DIV_W(2)) u_div (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(frame_tick),
      .fsel(ctl.fdiv), .adv(adv));

   lcd_slot_seq #(.N_COM(N_COM)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(run), .adv(adv),
      .duty(duty), .slot(slot), .pol(pol));

   lcd_disp_ram #(.N_SEG(N_SEG), .N_COM(N_COM), .ADDR_W(ADDR_W), .BASE(BASE)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .addr(ram_addr),
      .wdata(ram_wdata), .pix(pix));

   lcd_level_enc #(.N_COM(N_COM), .N_SEG(N_SEG)) u_enc (
      .clk(clk), .rst_n(rst_n), .run(run), .blank(ctl.blank), .bias3(bias3),
      .duty(duty), .slot(slot), .pol(pol), .pix(pix),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl));

   // R1
   stop_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (com_lvl == '0 && seg_lvl == '0));

   // R3
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !adv && !ctl_we && !ram_we) |=> $stable(com_lvl));

endmodule

// File: tb/lcd_wave_seq_test.sv
`timescale 1ns/1ps
module lcd_wave_seq_test;
   localparam int NC = 4;
   localparam int NS = 43;
   localparam int NB = 22;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            frame_tick = 1'b0;
   logic            ctl_we = 1'b0;
   logic [7:0]      ctl_wdata = '0;
   logic            ram_we = 1'b0;
   logic [7:0]      ram_addr = '0;
   logic [7:0]      ram_wdata = '0;
   logic [2*NC-1:0] com_lvl;
   logic [2*NS-1:0] seg_lvl;

   always #2 clk = ~clk;

   lcd_wave_seq uut (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
      .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .com_lvl(com_lvl), .seg_lvl(seg_lvl));

   int checks = 0;
   int errors = 0;
   logic [3:0] pix_m [NS];
   int acc [NC][NS];
   int m_mode = 0, m_slot = 0, m_pol = 0, m_blank = 0;

   function automatic logic [1:0] e_com(int c);
      bit b3 = (m_mode != 1);
      if (m_mode == 0) return 2'd0;
      if (c == m_slot) return m_pol ? 2'd0 : 2'd3;
      if (b3)          return m_pol ? 2'd2 : 2'd1;
      return 2'd1;
   endfunction

   function automatic logic [1:0] e_seg(int s);
      bit b3 = (m_mode != 1);
      bit on = pix_m[s][m_slot] && (m_blank == 0);
      if (m_mode == 0) return 2'd0;
      if (on)          return m_pol ? 2'd3 : 2'd0;
      if (b3)          return m_pol ? 2'd1 : 2'd2;
      return m_pol ? 2'd0 : 2'd3;
   endfunction

   function automatic int volt(logic [1:0] code);
      if (m_mode != 1) return int'(code);
      return (code == 2'd3) ? 2 : int'(code);
   endfunction

   task automatic check_outs(string tag);
      logic [2*NC-1:0] ec;
      logic [2*NS-1:0] es;
      for (int c = 0; c < NC; c++) ec[2*c +: 2] = e_com(c);
      for (int s = 0; s < NS; s++) es[2*s +: 2] = e_seg(s);
      checks++;
      if (com_lvl !== ec || seg_lvl !== es) begin
         errors++;
         $display("FAIL %s: com %h seg %h expected com %h seg %h", tag, com_lvl, seg_lvl, ec, es);
      end
   endtask

   task automatic accum();
      for (int c = 0; c < NC; c++)
         for (int s = 0; s < NS; s++)
            acc[c][s] += volt(com_lvl[2*c +: 2]) - volt(seg_lvl[2*s +: 2]);
   endtask

   task automatic wr_ctl(logic [7:0] v);
      ctl_wdata = v; ctl_we = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic wr_ram(logic [7:0] a, logic [7:0] d);
      ram_addr = a; ram_wdata = d; ram_we = 1'b1;
      @(negedge clk);
      ram_we = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse();
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic fill_ram();
      for (int b = 0; b < NB; b++) begin
         logic [7:0] d = 8'($urandom);
         wr_ram(8'h64 + 8'(b), d);
         pix_m[2*b] = d[3:0];
         if (2*b + 1 < NS) pix_m[2*b+1] = d[7:4];
      end
      // R10: outside the window, must not alter any pixel
      wr_ram(8'h63, 8'hFF);
      wr_ram(8'h7A, 8'hFF);
      wr_ram(8'h00, 8'hFF);
   endtask

   task automatic step_slot(int fp);
      int duty = m_mode + 1;
      for (int k = 1; k <= (1 << fp); k++) begin
         pulse();
         if (k < (1 << fp)) check_outs("R3 hold between divided ticks");
      end
      if (m_slot == duty - 1) begin
         m_slot = 0; m_pol ^= 1;
      end else m_slot++;
   endtask

   task automatic run_cfg(int mode, int fp, int blank, logic [7:0] extra);
      int duty = mode + 1;
      wr_ctl(8'h00);
      m_mode = 0;
      check_outs("R1 stopped outputs low");
      wr_ctl(extra | 8'(blank << 4) | 8'(mode << 2) | 8'(fp));
      m_mode = mode; m_blank = blank; m_slot = 0; m_pol = 0;
      check_outs("R12 restart at slot 0 polarity 0");
      for (int c = 0; c < NC; c++)
         for (int s = 0; s < NS; s++) acc[c][s] = 0;
      for (int st = 0; st < 2 * duty; st++) begin
         check_outs(blank != 0 ? "R9 blank" :
                    mode == 1  ? "R7 half bias" : "R5/R6/R8/R4 third bias");
         accum();
         step_slot(fp);
      end
      check_outs("R4 wrap after two frames");
      begin
         int bad = 0;
         for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++) if (acc[c][s] != 0) bad++;
         checks++;
         if (bad != 0) begin
            errors++;
            $display("FAIL R11 zero DC mode %0d: %0d cells nonzero, expected 0", mode, bad);
         end
      end
   endtask

   initial begin
      #500000;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int s = 0; s < NS; s++) pix_m[s] = '0;
      repeat (3) @(negedge clk);
      check_outs("R1 reset outputs low");
      rst_n = 1'b1;
      @(negedge clk);
      check_outs("R1 after reset");
      for (int mode = 1; mode <= 3; mode++) begin
         fill_ram();
         for (int fp = 0; fp < 4; fp++) run_cfg(mode, fp, 0, 8'h00);
      end
      // R2: bits 7:5 carry no function
      run_cfg(2, 1, 0, 8'hE0);
      // R9: blanked, commons keep running
      run_cfg(3, 0, 1, 8'h00);
      run_cfg(1, 0, 1, 8'h00);
      // R12: stop in mid-frame then restart
      wr_ctl(8'h0C);
      m_mode = 3; m_blank = 0; m_slot = 0; m_pol = 0;
      step_slot(0); step_slot(0);
      check_outs("R4 mid-frame slot 2");
      wr_ctl(8'h00);
      m_mode = 0;
      check_outs("R1 stop mid-frame");
      wr_ctl(8'h08);
      m_mode = 2; m_slot = 0; m_pol = 0;
      check_outs("R12 restart after mid-frame stop");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule